// File: doc/BRIEF.md
# External Interrupt Request Flag

This block turns an active-low external interrupt pin into a request flag that software can read. The pin is first brought into the clock domain through a short synchronizer. A type control bit then selects how the request is formed. When the bit is 1, a high-to-low transition of the pin raises the flag. When the bit is 0, a low pin raises the flag.

The interrupt controller sends a one-cycle acknowledge at the moment it vectors to the service routine. In edge mode that acknowledge consumes the pending request. In level mode the acknowledge does nothing, and the flag keeps following the inverted pin. Software can also write the flag directly. A write holds in edge mode. In level mode the pin state overrides it one cycle later.

The flag is a two-state machine with the states FLAG_IDLE (no request) and FLAG_PEND (request pending). The transitions are:
- SET_EDGE: FLAG_IDLE to FLAG_PEND on a synchronized falling edge in edge mode.
- CLR_ACK: FLAG_PEND to FLAG_IDLE on an acknowledge in edge mode, when no new edge arrives in the same cycle.
- LEVEL_FOLLOW: in level mode, the next state is FLAG_PEND exactly when the synchronized pin is low.
- SW_WRITE: a software write forces the state named by the write data, in either mode.

Top module: `extint_req_flag`

## Requirements
- R1: While reset is asserted and on the first cycle after it, req_flag is 0. The synchronizer resets to the idle-high pin level, so releasing reset with the pin high creates no request.
- R2: With trig_edge = 1, a falling edge on pin_n raises req_flag on the third rising clock edge after the pin changes, and not before.
- R3: With trig_edge = 1, req_flag holds its value when there is no falling edge, no acknowledge and no write, including when pin_n returns high.
- R4: With trig_edge = 1, an acknowledge pulse clears req_flag one cycle later, and the flag stays clear afterwards.
- R5: With trig_edge = 1, if a falling edge and an acknowledge land on the same cycle, req_flag is 1 afterwards.
- R6: With trig_edge = 0, req_flag equals the inverse of pin_n with a latency of three clock edges.
- R7: With trig_edge = 0, an acknowledge pulse leaves req_flag unchanged.
- R8: A write (sw_wr = 1) loads sw_wdata into req_flag on the next edge. In edge mode the written value then holds.
- R9: With trig_edge = 0, a written value is visible for one cycle, and on the following cycle the pin state replaces it.
- R10: Changing trig_edge creates no request on its own. With pin_n held low, switching from level to edge mode and then acknowledging leaves req_flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| trig_edge | input | 1 | Type bit: 1 selects falling edge, 0 selects low level |
| ack | input | 1 | One-cycle pulse sent when the service routine is vectored to |
| sw_wr | input | 1 | Software write strobe for the flag |
| sw_wdata | input | 1 | Value that a software write loads into the flag |
| req_flag | output | 1 | Request flag |

## Verification
In edge mode the pin is tried with three patterns:
- A single falling edge followed by a return high. This shows that an edge is latched and that a rising edge is not.
- An acknowledge on its own. This shows that the acknowledge clears a pending request.
- An acknowledge timed to land on the same cycle as a new edge. This shows that a fresh request is not lost to the clear.

In level mode the pin is held low and then released, and an acknowledge and a write are applied while it is low. This shows that the flag follows the pin and is not a latched request. A final sequence switches the type bit from level to edge mode while the pin is held low. It separates a real edge from an artefact of the mode change.

// File: rtl/extint_pkg.sv
package extint_pkg;
    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= RESET_VAL;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign dout = chain[LAST];
endmodule

// File: rtl/extint_fall_det.sv
module extint_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    output logic fall,
    output logic low
);
    logic pin_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= 1'b1;
        else        pin_prev <= pin_sync;
    end

    assign fall = pin_prev & ~pin_sync;
    assign low  = ~pin_sync;

    // R2: one edge yields a single-cycle detection
    p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/extint_flag_fsm.sv
module extint_flag_fsm
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_edge,
    input  logic fall,
    input  logic lvl_low,
    input  logic ack,
    input  logic sw_wr,
    input  logic sw_wdata,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (sw_wr) begin
            state_d = sw_wdata ? FLAG_PEND : FLAG_IDLE;           // SW_WRITE
        end else if (!trig_edge) begin
            state_d = lvl_low ? FLAG_PEND : FLAG_IDLE;            // LEVEL_FOLLOW
        end else begin
            unique case (state_q)
                FLAG_IDLE: if (fall) state_d = FLAG_PEND;         // SET_EDGE
                FLAG_PEND: if (ack && !fall) state_d = FLAG_IDLE; // CLR_ACK
                default:   state_d = FLAG_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_o = (state_q == FLAG_PEND);
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && !fall && !ack && !sw_wr) |=> $stable(flag_o));

    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && ack && !fall && !sw_wr) |=> !flag_o);

    p_fall_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && fall && !sw_wr) |=> flag_o);

    // R6 and R7: level mode follows the pin regardless of acknowledge
    p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_edge && !sw_wr) |=> (flag_o == $past(lvl_low)));

    p_sw_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr |=> (flag_o == $past(sw_wdata)));
endmodule

// File: rtl/extint_req_flag.sv
module extint_req_flag #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic trig_edge,
    input  logic ack,
    input  logic sw_wr,
    input  logic sw_wdata,
    output logic req_flag
);
    localparam bit PIN_IDLE = 1'b1;

    logic pin_sync;
    logic fall;
    logic lvl_low;

    extint_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(PIN_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_n),
        .dout (pin_sync)
    );

    extint_fall_det u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_sync(pin_sync),
        .fall    (fall),
        .low     (lvl_low)
    );

    extint_flag_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_edge(trig_edge),
        .fall     (fall),
        .lvl_low  (lvl_low),
        .ack      (ack),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .flag_o   (req_flag)
    );

    // R1: no request is ever present on the first cycle out of reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!req_flag || rst_n));
endmodule

// File: tb/extint_req_flag_tb.sv
module extint_req_flag_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic pin_n, trig_edge, ack, sw_wr, sw_wdata;
    logic req_flag;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int    due_q[$];
    bit    val_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    extint_req_flag dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (pin_n),
        .trig_edge(trig_edge),
        .ack      (ack),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .req_flag (req_flag)
    );

    task automatic expect_in(input int d, input bit v, input string tag);
        due_q.push_back(cyc + d);
        val_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected items and compares them, 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            bit    v;
            string t;
            void'(due_q.pop_front());
            v = val_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (req_flag !== v) begin
                n_bad++;
                $display("FAIL %s cycle %0d: req_flag=%b expected %b", t, cyc, req_flag, v);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_n = 1'b1; trig_edge = 1'b1;
        ack = 1'b0; sw_wr = 1'b0; sw_wdata = 1'b0;
        tick(3);
        expect_in(1, 1'b0, "R1");
        rst_n = 1'b1;
        expect_in(3, 1'b0, "R1");
        tick(4);

        // R2: falling edge in edge mode
        pin_n = 1'b0;
        expect_in(2, 1'b0, "R2");
        expect_in(3, 1'b1, "R2");
        tick(4);

        // R3: pin returning high does not disturb the latched flag
        pin_n = 1'b1;
        expect_in(3, 1'b1, "R3");
        expect_in(5, 1'b1, "R3");
        tick(6);

        // R4: acknowledge clears
        ack = 1'b1;
        expect_in(1, 1'b0, "R4");
        tick(1);
        ack = 1'b0;
        expect_in(3, 1'b0, "R4");
        tick(4);

        // R5: new edge coincides with acknowledge
        pin_n = 1'b0;
        expect_in(2, 1'b0, "R5");
        tick(2);
        ack = 1'b1;
        expect_in(1, 1'b1, "R5");
        tick(1);
        ack = 1'b0;
        expect_in(2, 1'b1, "R5");
        tick(3);
        pin_n = 1'b1;
        tick(3);
        ack = 1'b1;
        expect_in(1, 1'b0, "R4");
        tick(1);
        ack = 1'b0;
        tick(2);

        // R8: software write in edge mode sets then clears
        sw_wr = 1'b1; sw_wdata = 1'b1;
        expect_in(1, 1'b1, "R8");
        tick(1);
        sw_wr = 1'b0;
        expect_in(3, 1'b1, "R8");
        tick(4);
        sw_wr = 1'b1; sw_wdata = 1'b0;
        expect_in(1, 1'b0, "R8");
        tick(1);
        sw_wr = 1'b0;
        expect_in(3, 1'b0, "R8");
        tick(4);

        // level mode with the pin high: switching creates no request (R10)
        trig_edge = 1'b0;
        expect_in(1, 1'b0, "R10");
        tick(2);

        // R6: flag follows the low pin
        pin_n = 1'b0;
        expect_in(2, 1'b0, "R6");
        expect_in(3, 1'b1, "R6");
        tick(4);

        // R7: acknowledge ignored in level mode
        ack = 1'b1;
        expect_in(1, 1'b1, "R7");
        tick(1);
        ack = 1'b0;
        expect_in(1, 1'b1, "R7");
        tick(2);

        // R9: a write is overridden by the pin on the next cycle
        sw_wr = 1'b1; sw_wdata = 1'b0;
        expect_in(1, 1'b0, "R9");
        expect_in(2, 1'b1, "R9");
        tick(1);
        sw_wr = 1'b0;
        tick(3);

        // R6: release the pin
        pin_n = 1'b1;
        expect_in(2, 1'b1, "R6");
        expect_in(3, 1'b0, "R6");
        tick(4);
        pin_n = 1'b0;
        expect_in(3, 1'b1, "R6");
        tick(4);

        // R10: level to edge with the pin held low, then acknowledge
        trig_edge = 1'b1;
        expect_in(1, 1'b1, "R10");
        tick(1);
        ack = 1'b1;
        expect_in(1, 1'b0, "R10");
        tick(1);
        ack = 1'b0;
        expect_in(4, 1'b0, "R10");
        tick(6);

        if (due_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: %0d items left, expected 0", due_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule